// File: doc/BRIEF.md
# Video Field and Frame Capture Sequencer

This block decides, field by field, whether an interlaced or progressive video input port may write pixels. A 4-bit mode word `{continuous, frame, cf2, cf1}` selects which fields are wanted and how completion status governs further capture. The pixel path signals the start and end of each field with one-cycle strobes, tagged with the field number. The sequencer answers with a capture enable that is held for the whole field. It also keeps three sticky completion flags (field 1, field 2, frame), pulses a completion event, and reports when frame capture is halted.

The flags hold-off behaviour depends on the mode:

- **Field modes.** A field is refused while its own flag is still set.
- **Interlaced and progressive frame modes.** Capture stops after a frame that completes while the frame flag is already set.
- **Single-frame mode.** Capture stops after every frame.
- **Continuous modes.** The flags are recorded but never consulted.

Software clears a flag with a one-cycle pulse.

All pins are plain control and status levels or strobes. There is no data stream crossing this block, so it has no valid/ready handshake and no back-pressure. The pixel path must gate its writes with the capture enable.

Top module: `vcs_capture_seq`

## Requirements
- R1: Reserved mode codes 0000, 0110, 1000 and 1110 never raise the capture enable and never set a flag.
- R2: The capture decision is taken only at a field-start strobe (`fld_id_i` 0 = field 1, 1 = field 2). The enable is high from the cycle after the strobe until the cycle after the field-end strobe. A flag cleared partway through a field changes nothing until the next field start.
- R3: Mode 0001 captures only field 1, sets the field-1 flag at its end, and refuses field 1 while that flag is set.
- R4: Mode 0010 captures only field 2, sets the field-2 flag at its end, and refuses field 2 while that flag is set.
- R5: Mode 0011 captures both fields. Each field is gated only by its own flag, and each flag is set at the end of its own field.
- R6: Mode 0100 captures both fields and sets the frame flag at the end of field 2. If a frame completes while that flag is already set, the halted output rises and no field is captured. After the flag is cleared, capture resumes at the next field-1 start.
- R7: Mode 0101 captures only field 1 and sets the frame flag at its end. It halts after a field 1 that completes with the frame flag already set.
- R8: Mode 0111 captures one frame (both fields), sets the frame flag at the end of field 2 and halts. Capture stays halted until the frame flag is cleared.
- R9: Continuous modes (code bit 3 set) capture the same fields as their counterparts and set the same flags. They never refuse a field because of a flag and never halt.
- R10: The completion event is a one-cycle pulse, one cycle after a field end that set any flag. A low `evt_en_i` suppresses the pulse but not the flag.
- R11: A clear pulse in the same cycle as the set of the same flag is lost, and the flag stays set.
- R12: A field start that sees a mode word different from the one seen at the previous field start releases the halted state before deciding that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Mode word {continuous, frame, cf2, cf1} |
| fld_start_i | input | 1 | One-cycle field-start strobe |
| fld_end_i | input | 1 | One-cycle field-end strobe |
| fld_id_i | input | 1 | Field number at the start strobe (0 field 1, 1 field 2) |
| clr_f1_i | input | 1 | Clear pulse for the field-1 flag |
| clr_f2_i | input | 1 | Clear pulse for the field-2 flag |
| clr_frm_i | input | 1 | Clear pulse for the frame flag |
| evt_en_i | input | 1 | Completion event enable |
| cap_en_o | output | 1 | Capture enable for the current field |
| f1_done_o | output | 1 | Field-1 complete flag |
| f2_done_o | output | 1 | Field-2 complete flag |
| frm_done_o | output | 1 | Frame complete flag |
| cmp_evt_o | output | 1 | One-cycle completion event |
| halted_o | output | 1 | Frame capture halted |

## Verification
The bench builds the block with the package defaults: a 4-bit mode word and three flags. With these, every one of the sixteen mode codes can be driven, including the reserved ones and their continuous twins. Each directed scenario walks a short sequence of fields. That is long enough to reach the second-frame halt, a release that lands in the middle of a frame, a clear that lands inside a field or on the same cycle as a set, and a mode change that lifts a halt.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int MODE_W = 4;
  localparam int NFLAG  = 3;
  localparam int FL_F1  = 0;
  localparam int FL_F2  = 1;
  localparam int FL_FRM = 2;

  typedef struct packed {
    logic cont;
    logic frame;
    logic cf2;
    logic cf1;
  } mode_t;

  typedef struct packed {
    logic valid;
    logic want_f1;
    logic want_f2;
    logic fld_gate;
    logic f1_flag;
    logic f2_flag;
    logic frm_flag;
    logic frm_on_f2;
    logic next_halt;
    logic single_halt;
    logic frame_seq;
  } plan_t;
endpackage

// File: rtl/vcs_mode_dec.sv
module vcs_mode_dec
  import vcs_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output plan_t             plan_o
);
  mode_t m;
  assign m = mode_t'(mode_i);

  always_comb begin
    plan_o = '0;
    if (!m.frame) begin
      // field modes: 00 in the field bits is reserved
      plan_o.valid    = m.cf1 | m.cf2;
      plan_o.want_f1  = m.cf1;
      plan_o.want_f2  = m.cf2;
      plan_o.f1_flag  = m.cf1;
      plan_o.f2_flag  = m.cf2;
      plan_o.fld_gate = !m.cont;
    end else begin
      unique case ({m.cf2, m.cf1})
        2'b00: begin // interlaced frame, halt after next frame
          plan_o.valid     = 1'b1;
          plan_o.want_f1   = 1'b1;
          plan_o.want_f2   = 1'b1;
          plan_o.frm_flag  = 1'b1;
          plan_o.frm_on_f2 = 1'b1;
          plan_o.next_halt = !m.cont;
          plan_o.frame_seq = 1'b1;
        end
        2'b01: begin // progressive frame carried in field 1
          plan_o.valid     = 1'b1;
          plan_o.want_f1   = 1'b1;
          plan_o.frm_flag  = 1'b1;
          plan_o.next_halt = !m.cont;
        end
        2'b11: begin // one frame, then wait for clear
          plan_o.valid       = 1'b1;
          plan_o.want_f1     = 1'b1;
          plan_o.want_f2     = 1'b1;
          plan_o.frm_flag    = 1'b1;
          plan_o.frm_on_f2   = 1'b1;
          plan_o.single_halt = !m.cont;
          plan_o.frame_seq   = 1'b1;
        end
        default: ; // 10 with frame set is reserved
      endcase
    end
  end
endmodule

// File: rtl/vcs_field_gate.sv
module vcs_field_gate
  import vcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  plan_t             plan_i,
  input  logic              fld_start_i,
  input  logic              fld_end_i,
  input  logic              fld_id_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic              halt_i,
  output logic              cap_en_o,
  output logic              cur_fld_o,
  output logic              mode_chg_o
);
  logic [MODE_W-1:0] mode_seen_q;
  logic frame_open_q, cap_q, fld_q;
  logic halt_eff, want, allow, grant;
  logic plan_unused;

  assign plan_unused = ^{plan_i.f1_flag, plan_i.f2_flag, plan_i.frm_flag,
                         plan_i.frm_on_f2, flags_i[FL_FRM]};

  assign mode_chg_o = fld_start_i && (mode_i != mode_seen_q);
  assign halt_eff   = halt_i && !mode_chg_o;

  always_comb begin
    want  = fld_id_i ? plan_i.want_f2 : plan_i.want_f1;
    allow = 1'b1;
    if (plan_i.fld_gate)
      allow = fld_id_i ? !flags_i[FL_F2] : !flags_i[FL_F1];
    if (plan_i.next_halt || plan_i.single_halt)
      allow = allow && !halt_eff;
    if (plan_i.frame_seq && fld_id_i)
      allow = allow && frame_open_q;
    grant = plan_i.valid && want && allow;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_seen_q  <= '0;
      frame_open_q <= 1'b0;
      cap_q        <= 1'b0;
      fld_q        <= 1'b0;
    end else if (fld_start_i) begin
      cap_q       <= grant;
      fld_q       <= fld_id_i;
      mode_seen_q <= mode_i;
      if (!fld_id_i) frame_open_q <= grant;
    end else if (fld_end_i) begin
      cap_q <= 1'b0;
    end
  end

  assign cap_en_o  = cap_q;
  assign cur_fld_o = fld_q;

  assert_reserved_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i && !plan_i.valid |=> !cap_en_o);
  assert_end_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_end_i && !fld_start_i |=> !cap_en_o);
  assert_hold_in_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fld_start_i && !fld_end_i |=> $stable(cap_en_o));
  assert_f1_refused_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i && plan_i.fld_gate && !fld_id_i && flags_i[FL_F1] |=> !cap_en_o);
  assert_f2_refused_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i && plan_i.fld_gate && fld_id_i && flags_i[FL_F2] |=> !cap_en_o);
  assert_halt_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i && plan_i.next_halt && halt_i && !mode_chg_o |=> !cap_en_o);
  assert_single_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i && plan_i.single_halt && halt_i && !mode_chg_o |=> !cap_en_o);
endmodule

// File: rtl/vcs_flag_unit.sv
module vcs_flag_unit
  import vcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  plan_t            plan_i,
  input  logic             fld_end_i,
  input  logic             cap_en_i,
  input  logic             cur_fld_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             evt_en_i,
  input  logic             mode_chg_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             evt_o,
  output logic             halt_o
);
  logic [NFLAG-1:0] set_v, flag_q;
  logic fin, halt_set, halt_q, evt_q;
  logic plan_unused;

  assign plan_unused = ^{plan_i.valid, plan_i.want_f1, plan_i.want_f2,
                         plan_i.fld_gate, plan_i.frame_seq};

  assign fin = fld_end_i && cap_en_i;

  always_comb begin
    set_v         = '0;
    set_v[FL_F1]  = fin && plan_i.f1_flag && !cur_fld_i;
    set_v[FL_F2]  = fin && plan_i.f2_flag && cur_fld_i;
    set_v[FL_FRM] = fin && plan_i.frm_flag && (cur_fld_i == plan_i.frm_on_f2);
  end

  // set has priority over a clear arriving in the same cycle
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_v[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign halt_set = set_v[FL_FRM] &&
                    (plan_i.single_halt || (plan_i.next_halt && flag_q[FL_FRM]));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= (|set_v) && evt_en_i;
      if (halt_set)                          halt_q <= 1'b1;
      else if (mode_chg_i || clr_i[FL_FRM])  halt_q <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign evt_o   = evt_q;
  assign halt_o  = halt_q;

  assert_f1_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_end_i && cap_en_i && !cur_fld_i && plan_i.f1_flag |=> flags_o[FL_F1]);
  assert_f1_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[FL_F1] && !fld_end_i |=> !flags_o[FL_F1]);
  assert_evt_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  assert_evt_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_en_i |=> !evt_o);
  assert_mode_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i && !fld_end_i |=> !halt_o);
  assert_cont_no_halt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !plan_i.next_halt && !plan_i.single_halt && !halt_o |=> !halt_o);
endmodule

// File: rtl/vcs_capture_seq.sv
module vcs_capture_seq
  import vcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              fld_start_i,
  input  logic              fld_end_i,
  input  logic              fld_id_i,
  input  logic              clr_f1_i,
  input  logic              clr_f2_i,
  input  logic              clr_frm_i,
  input  logic              evt_en_i,
  output logic              cap_en_o,
  output logic              f1_done_o,
  output logic              f2_done_o,
  output logic              frm_done_o,
  output logic              cmp_evt_o,
  output logic              halted_o
);
  plan_t            plan;
  logic [NFLAG-1:0] flags, clr;
  logic             cap_en, cur_fld, mode_chg, halt;

  always_comb begin
    clr         = '0;
    clr[FL_F1]  = clr_f1_i;
    clr[FL_F2]  = clr_f2_i;
    clr[FL_FRM] = clr_frm_i;
  end

  vcs_mode_dec u_dec (
    .mode_i (mode_i),
    .plan_o (plan)
  );

  vcs_field_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .plan_i      (plan),
    .fld_start_i (fld_start_i),
    .fld_end_i   (fld_end_i),
    .fld_id_i    (fld_id_i),
    .flags_i     (flags),
    .halt_i      (halt),
    .cap_en_o    (cap_en),
    .cur_fld_o   (cur_fld),
    .mode_chg_o  (mode_chg)
  );

  vcs_flag_unit u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .plan_i     (plan),
    .fld_end_i  (fld_end_i),
    .cap_en_i   (cap_en),
    .cur_fld_i  (cur_fld),
    .clr_i      (clr),
    .evt_en_i   (evt_en_i),
    .mode_chg_i (mode_chg),
    .flags_o    (flags),
    .evt_o      (cmp_evt_o),
    .halt_o     (halt)
  );

  assign cap_en_o   = cap_en;
  assign f1_done_o  = flags[FL_F1];
  assign f2_done_o  = flags[FL_F2];
  assign frm_done_o = flags[FL_FRM];
  assign halted_o   = halt;
endmodule

// File: tb/test_vcs_capture_seq.sv
module test_vcs_capture_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] mode;
  logic fld_start, fld_end, fld_id, clr_f1, clr_f2, clr_frm, evt_en;
  logic cap_en, f1_done, f2_done, frm_done, cmp_evt, halted;
  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  vcs_capture_seq i_vcs_capture_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .fld_start_i(fld_start), .fld_end_i(fld_end), .fld_id_i(fld_id),
    .clr_f1_i(clr_f1), .clr_f2_i(clr_f2), .clr_frm_i(clr_frm),
    .evt_en_i(evt_en), .cap_en_o(cap_en), .f1_done_o(f1_done),
    .f2_done_o(f2_done), .frm_done_o(frm_done), .cmp_evt_o(cmp_evt),
    .halted_o(halted)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; fld_start = 0; fld_end = 0; fld_id = 0;
    clr_f1 = 0; clr_f2 = 0; clr_frm = 0; evt_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_clear(input logic [2:0] m);
    @(negedge clk); {clr_frm, clr_f2, clr_f1} = m;
    @(negedge clk); {clr_frm, clr_f2, clr_f1} = 3'b000;
  endtask

  // one field: mid_clr pulses inside the field, end_clr with the end strobe
  task automatic run_field(input logic id, input logic [2:0] mid_clr,
                           input logic [2:0] end_clr, output logic cap,
                           output logic cap_mid, output logic evt);
    @(negedge clk); fld_start = 1; fld_id = id;
    @(negedge clk); fld_start = 0; cap = cap_en;
    @(negedge clk); {clr_frm, clr_f2, clr_f1} = mid_clr;
    @(negedge clk); {clr_frm, clr_f2, clr_f1} = 3'b000;
    @(negedge clk); cap_mid = cap_en;
    fld_end = 1; {clr_frm, clr_f2, clr_f1} = end_clr;
    @(negedge clk); fld_end = 0; {clr_frm, clr_f2, clr_f1} = 3'b000;
    evt = cmp_evt;
    @(negedge clk);
    check("R2 enable low after field end", int'(cap_en), 0);
  endtask

  task automatic fld(input logic id, output logic cap, output logic evt);
    logic dummy;
    run_field(id, 3'b000, 3'b000, cap, dummy, evt);
  endtask

  task automatic t_reset;
    do_reset(4'b0001);
    check("R2 reset cap_en", int'(cap_en), 0);
    check("R2 reset flags", int'({frm_done, f2_done, f1_done}), 0);
    check("R2 reset halted", int'(halted), 0);
    check("R10 reset event", int'(cmp_evt), 0);
  endtask

  task automatic t_reserved;
    logic [3:0] codes [4] = '{4'b0000, 4'b0110, 4'b1000, 4'b1110};
    logic c, e;
    for (int i = 0; i < 4; i++) begin
      do_reset(codes[i]);
      fld(1'b0, c, e); check("R1 reserved field 1 cap", int'(c), 0);
      fld(1'b1, c, e); check("R1 reserved field 2 cap", int'(c), 0);
      check("R1 reserved flags", int'({frm_done, f2_done, f1_done}), 0);
    end
  endtask

  task automatic t_field1;
    logic c, cm, e;
    do_reset(4'b0001);
    fld(1'b0, c, e);
    check("R3 f1 captured", int'(c), 1);
    check("R3 f1 event", int'(e), 1);
    check("R3 f1 flag", int'(f1_done), 1);
    fld(1'b1, c, e); check("R3 f2 not captured", int'(c), 0);
    run_field(1'b0, 3'b001, 3'b000, c, cm, e);
    check("R3 f1 refused while flag set", int'(c), 0);
    check("R2 mid-field clear keeps enable low", int'(cm), 0);
    check("R2 mid-field clear took flag", int'(f1_done), 0);
    fld(1'b0, c, e); check("R3 f1 resumes after clear", int'(c), 1);
  endtask

  task automatic t_field2;
    logic c, e;
    do_reset(4'b0010);
    fld(1'b0, c, e); check("R4 f1 not captured", int'(c), 0);
    fld(1'b1, c, e);
    check("R4 f2 captured", int'(c), 1);
    check("R4 f2 flag", int'(f2_done), 1);
    check("R4 f1 flag untouched", int'(f1_done), 0);
    fld(1'b1, c, e); check("R4 f2 refused", int'(c), 0);
    pulse_clear(3'b010);
    fld(1'b1, c, e); check("R4 f2 resumes", int'(c), 1);
  endtask

  task automatic t_both;
    logic c, e;
    do_reset(4'b0011);
    fld(1'b0, c, e); check("R5 f1 captured", int'(c), 1);
    fld(1'b1, c, e); check("R5 f2 captured", int'(c), 1);
    check("R5 both flags", int'({f2_done, f1_done}), 3);
    pulse_clear(3'b010);
    fld(1'b0, c, e); check("R5 f1 gated by own flag", int'(c), 0);
    fld(1'b1, c, e); check("R5 f2 independent", int'(c), 1);
  endtask

  task automatic t_frame;
    logic c, e;
    do_reset(4'b0100);
    fld(1'b0, c, e);
    check("R6 f1 captured", int'(c), 1);
    check("R6 no event after f1", int'(e), 0);
    fld(1'b1, c, e);
    check("R6 f2 captured", int'(c), 1);
    check("R6 frame flag", int'(frm_done), 1);
    check("R6 not yet halted", int'(halted), 0);
    fld(1'b0, c, e); check("R6 second frame f1", int'(c), 1);
    fld(1'b1, c, e); check("R6 second frame f2", int'(c), 1);
    check("R6 halted after second frame", int'(halted), 1);
    fld(1'b0, c, e); check("R6 halted f1", int'(c), 0);
    pulse_clear(3'b100);
    check("R6 release", int'(halted), 0);
    fld(1'b1, c, e); check("R6 no mid-frame restart", int'(c), 0);
    fld(1'b0, c, e); check("R6 restart at f1", int'(c), 1);
    fld(1'b1, c, e); check("R6 restart f2", int'(c), 1);
  endtask

  task automatic t_prog;
    logic c, e;
    do_reset(4'b0101);
    fld(1'b0, c, e);
    check("R7 f1 captured", int'(c), 1);
    check("R7 frame flag at f1 end", int'(frm_done), 1);
    fld(1'b1, c, e); check("R7 f2 skipped", int'(c), 0);
    fld(1'b0, c, e); check("R7 next frame", int'(c), 1);
    check("R7 halted", int'(halted), 1);
    fld(1'b0, c, e); check("R7 halted f1", int'(c), 0);
    pulse_clear(3'b100);
    fld(1'b0, c, e); check("R7 resumes", int'(c), 1);
  endtask

  task automatic t_single;
    logic c, e;
    do_reset(4'b0111);
    fld(1'b0, c, e); check("R8 f1 captured", int'(c), 1);
    fld(1'b1, c, e); check("R8 f2 captured", int'(c), 1);
    check("R8 halted after one frame", int'({halted, frm_done}), 3);
    fld(1'b0, c, e); check("R8 blocked", int'(c), 0);
    pulse_clear(3'b100);
    fld(1'b0, c, e); check("R8 resumes", int'(c), 1);
    fld(1'b1, c, e); check("R8 halts again", int'(halted), 1);
  endtask

  task automatic t_cont;
    logic c, e;
    do_reset(4'b1001);
    fld(1'b0, c, e); check("R9 cont f1", int'(c), 1);
    fld(1'b0, c, e); check("R9 cont f1 ignores flag", int'(c), 1);
    check("R9 cont event repeats", int'(e), 1);
    fld(1'b1, c, e); check("R9 cont f2 skipped", int'(c), 0);
    do_reset(4'b1100);
    for (int i = 0; i < 3; i++) begin
      fld(1'b0, c, e); check("R9 cont frame f1", int'(c), 1);
      fld(1'b1, c, e); check("R9 cont frame f2", int'(c), 1);
    end
    check("R9 cont never halts", int'(halted), 0);
  endtask

  task automatic t_evt_mask;
    logic c, e;
    do_reset(4'b0001);
    evt_en = 1'b0;
    fld(1'b0, c, e);
    check("R10 masked event", int'(e), 0);
    check("R10 flag still set", int'(f1_done), 1);
    evt_en = 1'b1;
    pulse_clear(3'b001);
    fld(1'b0, c, e);
    check("R10 event one cycle", int'(cmp_evt), 0);
  endtask

  task automatic t_set_wins;
    logic c, cm, e;
    do_reset(4'b0001);
    run_field(1'b0, 3'b000, 3'b001, c, cm, e);
    check("R11 set beats clear", int'(f1_done), 1);
  endtask

  task automatic t_mode_chg;
    logic c, e;
    do_reset(4'b0111);
    fld(1'b0, c, e);
    fld(1'b1, c, e);
    check("R12 halted before change", int'(halted), 1);
    @(negedge clk); mode = 4'b0100;
    fld(1'b0, c, e);
    check("R12 capture after mode change", int'(c), 1);
    check("R12 halt released", int'(halted), 0);
  endtask

  task automatic run_all;
    t_reset();
    t_reserved();
    t_field1();
    t_field2();
    t_both();
    t_frame();
    t_prog();
    t_single();
    t_cont();
    t_evt_mask();
    t_set_wins();
    t_mode_chg();
  endtask

  initial begin
    rst_n = 1'b0; mode = '0; fld_start = 0; fld_end = 0; fld_id = 0;
    clr_f1 = 0; clr_f2 = 0; clr_frm = 0; evt_en = 1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule